// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder that settles every carry through two tiers of lookahead. The operands are split into four 4-bit slices. Each slice derives per-bit generate (both operand bits set) and propagate (either operand bit set) terms. From these it forms its internal carries in fully expanded sum-of-products form. Each slice also summarises itself as one group propagate and one group generate.

A second tier applies the same expanded equations to the four group summaries. It produces the carries entering slices 1, 2 and 3 and the final carry-out. No carry ever ripples from one slice to the next.

The block is meant to sit inside a datapath where the sum must settle within one clock period. It also exports the group propagate and generate terms, so that a wider adder can stack a further lookahead tier on top.

Top module: `cla2_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `a + b + cin`, taken as unsigned values.
- R2: `cout` equals bit 16 of the 17-bit unsigned result `a + b + cin`.
- R3: `grp_p[k]` is 1 exactly when every bit position i in slice k (bits 4k to 4k+3) has `a[i] | b[i]` set.
- R4: `grp_g[k]` is 1 exactly when the 4-bit slice k of `a` plus the same slice of `b` produces a carry out of the slice with a zero carry into it.
- R5: A carry-in of 1 travels through every slice when all operand bits propagate: with `a` = 0xFFFF, `b` = 0x0000 and `cin` = 1, `sum` is 0x0000 and `cout` is 1.
- R6: With both operands zero, `sum` equals `cin` and `cout` is 0.
- R7: When every slice propagates and none generates (for example `a` = 0xAAAA, `b` = 0x5555), `cout` equals `cin` and `sum` is 0xFFFF+`cin` truncated.
- R8: A slice that generates forces a carry of 1 into the next slice whatever `cin` is: `a` = 0x000F, `b` = 0x0001 gives `sum` = 0x0010 + `cin` for both values of `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_p | output | 4 | Group propagate, one bit per 4-bit slice |
| grp_g | output | 4 | Group generate, one bit per 4-bit slice |

## Verification
A wrong group propagate or generate term shows up on `grp_p`/`grp_g` right away. It also corrupts the carry entering every higher slice, so whole nibbles of `sum`, or `cout`, come out wrong in the same evaluation. Because the block holds no state, each fault is visible at the ports with the operands that trigger it. The stimulus therefore includes long propagate chains, slices that generate, and both values of the carry-in. These are the cases that expose a missing product term in either lookahead tier.

// File: rtl/cla2_pkg.sv
// Package: shared constants and the expanded lookahead carry function.
// Assumes callers zero-pad generate/propagate vectors up to LA_MAX bits.
package cla2_pkg;
    localparam int DEF_WIDTH = 16;
    localparam int DEF_GRP_W = 4;
    localparam int LA_MAX    = 16;

    // Carry out of positions 0..k-1, written as the flat OR of product terms
    // (g_j gated by every propagate above j, plus c0 gated by all propagates).
    function automatic logic la_carry(input logic [LA_MAX-1:0] gv,
                                      input logic [LA_MAX-1:0] pv,
                                      input logic              c0,
                                      input int                k);
        logic orv;
        logic term;
        term = c0;
        for (int j = 0; j < LA_MAX; j++) begin
            if (j < k) term = term & pv[j];
        end
        orv = term;
        for (int j = 0; j < LA_MAX; j++) begin
            if (j < k) begin
                term = gv[j];
                for (int m = 0; m < LA_MAX; m++) begin
                    if (m > j && m < k) term = term & pv[m];
                end
                orv = orv | term;
            end
        end
        return orv;
    endfunction
endpackage

// File: rtl/cla2_group.sv
// Module: one carry-lookahead slice of GW bits.
// Forms per-bit generate/propagate, all internal carries in expanded form,
// the slice sum, and the group propagate/generate summary.
// Assumes GW <= cla2_pkg::LA_MAX.
module cla2_group #(
    parameter int GW = cla2_pkg::DEF_GRP_W
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] sum,
    output logic          grp_p,
    output logic          grp_g
);
    import cla2_pkg::*;

    logic [LA_MAX-1:0] g_ext;
    logic [LA_MAX-1:0] p_ext;
    logic [GW:0]       c;

    // Per-bit generate and propagate, zero-padded for the shared function.
    always_comb begin
        g_ext = '0;
        p_ext = '0;
        g_ext[GW-1:0] = a & b;
        p_ext[GW-1:0] = a | b;
    end

    // Every internal carry straight from g, p and the slice carry-in.
    always_comb begin
        for (int k = 0; k <= GW; k++) begin
            c[k] = la_carry(g_ext, p_ext, cin, k);
        end
    end

    // Sum bits and the group summary terms.
    always_comb begin
        sum   = a ^ b ^ c[GW-1:0];
        grp_p = &p_ext[GW-1:0];
        grp_g = la_carry(g_ext, p_ext, 1'b0, GW);
    end

    // Checks that the slice's own carry-out agrees with its summary terms.
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            p_grp_carry_r4: assert (c[GW] == (grp_g | (grp_p & cin)))
                else $error("slice carry-out disagrees with group P/G");
            p_grp_gen_r8: assert (!grp_g || c[GW])
                else $error("generating slice did not carry out");
            p_grp_kill_r3: assert (grp_p || grp_g || !c[GW])
                else $error("non-propagating slice passed a carry");
        end
    end
endmodule

// File: rtl/cla2_lookahead.sv
// Module: second-tier lookahead across NG slices.
// Takes group propagate/generate and the adder carry-in, and returns the
// carry into every slice plus the final carry-out in gc[NG].
// Assumes NG <= cla2_pkg::LA_MAX.
module cla2_lookahead #(
    parameter int NG = cla2_pkg::DEF_WIDTH / cla2_pkg::DEF_GRP_W
) (
    input  logic [NG-1:0] gp,
    input  logic [NG-1:0] gg,
    input  logic          cin,
    output logic [NG:0]   gc
);
    import cla2_pkg::*;

    logic [LA_MAX-1:0] gg_ext;
    logic [LA_MAX-1:0] gp_ext;

    // Zero-pad the group terms for the shared function.
    always_comb begin
        gg_ext = '0;
        gp_ext = '0;
        gg_ext[NG-1:0] = gg;
        gp_ext[NG-1:0] = gp;
    end

    // Slice carries, each expanded directly from the group terms and cin.
    always_comb begin
        for (int k = 0; k <= NG; k++) begin
            gc[k] = la_carry(gg_ext, gp_ext, cin, k);
        end
    end

    // Pure propagate chain passes cin; any top generate forces a carry.
    always_comb begin
        if (!$isunknown({gp, gg, cin})) begin
            p_all_prop_r7: assert (!((&gp) && !(|gg)) || (gc[NG] == cin))
                else $error("propagate chain did not pass carry-in");
            p_top_gen_r2: assert (!gg[NG-1] || gc[NG])
                else $error("top slice generated but no carry-out");
        end
    end
endmodule

// File: rtl/cla2_adder.sv
// Module: WIDTH-bit adder from GRP_W-bit lookahead slices joined by a
// second lookahead tier. Purely combinational; no clock or reset.
// Assumes WIDTH is a multiple of GRP_W.
module cla2_adder #(
    parameter int WIDTH = cla2_pkg::DEF_WIDTH,
    parameter int GRP_W = cla2_pkg::DEF_GRP_W
) (
    input  logic [WIDTH-1:0]       a,
    input  logic [WIDTH-1:0]       b,
    input  logic                   cin,
    output logic [WIDTH-1:0]       sum,
    output logic                   cout,
    output logic [WIDTH/GRP_W-1:0] grp_p,
    output logic [WIDTH/GRP_W-1:0] grp_g
);
    localparam int NG = WIDTH / GRP_W;

    logic [NG:0] gc;

    // One lookahead slice per GRP_W bits, fed by the second tier.
    for (genvar k = 0; k < NG; k++) begin : g_slice
        cla2_group #(.GW(GRP_W)) u_grp (
            .a     (a[k*GRP_W +: GRP_W]),
            .b     (b[k*GRP_W +: GRP_W]),
            .cin   (gc[k]),
            .sum   (sum[k*GRP_W +: GRP_W]),
            .grp_p (grp_p[k]),
            .grp_g (grp_g[k])
        );
    end

    cla2_lookahead #(.NG(NG)) u_la (
        .gp  (grp_p),
        .gg  (grp_g),
        .cin (cin),
        .gc  (gc)
    );

    // Final carry-out is the top carry of the second tier.
    always_comb cout = gc[NG];

    // Whole result matches ordinary unsigned addition.
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            p_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
                else $error("sum/carry-out mismatch");
        end
    end
endmodule

// File: tb/sim_cla2_adder.sv
// Bench: drives operands after each rising edge, compares against a
// behavioural 17-bit addition on the following falling edge.
module sim_cla2_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    logic [3:0]  grp_p;
    logic [3:0]  grp_g;

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cla2_adder u0 (
        .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
    );

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000 && !done) begin
            done = 1'b1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one vector and compare every output to the behavioural model.
    task automatic run_vec(input logic [15:0] va, input logic [15:0] vb,
                           input logic vc, input string note);
        logic [16:0] full;
        logic [3:0]  ep, eg;
        @(posedge clk);
        a = va; b = vb; cin = vc;
        full = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
        for (int k = 0; k < 4; k++) begin
            logic [4:0] part;
            ep[k] = &(va[k*4 +: 4] | vb[k*4 +: 4]);
            part  = {1'b0, va[k*4 +: 4]} + {1'b0, vb[k*4 +: 4]};
            eg[k] = part[4];
        end
        @(negedge clk);
        check({"R1 sum ", note}, {16'd0, sum}, {16'd0, full[15:0]});
        check({"R2 cout ", note}, {31'd0, cout}, {31'd0, full[16]});
        check({"R3 grp_p ", note}, {28'd0, grp_p}, {28'd0, ep});
        check({"R4 grp_g ", note}, {28'd0, grp_g}, {28'd0, eg});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial state with all-zero operands.
        @(negedge clk);
        check("R6 idle sum", {16'd0, sum}, 32'd0);
        check("R6 idle cout", {31'd0, cout}, 32'd0);

        run_vec(16'h0000, 16'h0000, 1'b1, "R6 zero+cin");
        run_vec(16'hFFFF, 16'h0000, 1'b1, "R5 chain");
        run_vec(16'h0000, 16'hFFFF, 1'b1, "R5 chain swap");
        run_vec(16'hFFFF, 16'h0001, 1'b0, "R5 ones+1");
        run_vec(16'hFFFF, 16'hFFFF, 1'b1, "ones+ones");
        run_vec(16'hAAAA, 16'h5555, 1'b0, "R7 alt cin0");
        run_vec(16'hAAAA, 16'h5555, 1'b1, "R7 alt cin1");
        run_vec(16'h5555, 16'h5555, 1'b0, "alt same");
        run_vec(16'h000F, 16'h0001, 1'b0, "R8 gen cin0");
        run_vec(16'h000F, 16'h0001, 1'b1, "R8 gen cin1");
        run_vec(16'h0F0F, 16'h0101, 1'b1, "R8 gen pair");
        run_vec(16'h8000, 16'h8000, 1'b0, "top gen");
        for (int i = 0; i < 400; i++) begin
            run_vec(16'($urandom), 16'($urandom), 1'($urandom), "random");
        end

        // Direct port-level checks of the named corner results.
        @(posedge clk); a = 16'hFFFF; b = 16'h0000; cin = 1'b1;
        @(negedge clk);
        check("R5 direct sum", {16'd0, sum}, 32'd0);
        check("R5 direct cout", {31'd0, cout}, 32'd1);
        @(posedge clk); a = 16'hAAAA; b = 16'h5555; cin = 1'b1;
        @(negedge clk);
        check("R7 direct cout", {31'd0, cout}, 32'd1);
        check("R7 direct grp_g", {28'd0, grp_g}, 32'd0);
        @(posedge clk); a = 16'h000F; b = 16'h0001; cin = 1'b0;
        @(negedge clk);
        check("R8 direct sum", {16'd0, sum}, 32'h10);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule